// File: doc/BRIEF.md
# Dual-Port Pipelined Byte-Lane RAM

A synchronous random-access memory with two symmetric access ports, A and B. Either port can read or write any word in the same cycle as the other port. Each port captures its address, write data, lane enables and control lines in registers on the rising clock edge. The array read register then acts as the output stage, so read data leaves the block one cycle after the access was captured.

A word has two lanes of `LANE_W` bits. Each lane has its own active-low enable, so a write can touch one lane or both, and a read drives only the lanes that asked for it. Each port has two select inputs of opposite polarity, which lets several instances share an address bus for depth expansion with no decoder. There are no internal tri-states. Each port instead reports a per-lane `drive` vector, and a pad ring or bus mux uses it to decide which lanes of `rdata` reach the wire. The output-enable input gates `drive` combinationally, without waiting for a clock.

The default build is 1024 words of 18 bits (`ADDR_W` = 10). Setting `ADDR_W` = 15 gives the full 32768-word array. Both ports run on the single clock `clk`.

Top module: `dpr_dualport`

## Requirements
- R1: Any word written through one port reads back unchanged through either port, at every address from 0 to 2**ADDR_W-1. The word is `LANES`*`LANE_W` bits wide, 18 by default.
- R2: A port takes part in an access only when `x_sel_n` is 0 and `x_sel` is 1. With any other combination the port writes nothing, and one cycle later `x_drive` is 0.
- R3: Lane enable bit 0 guards data bits 8:0 and bit 1 guards bits 17:9. A value of 0 enables the lane. A write changes only the enabled lanes, and the other lanes keep their old contents.
- R4: A write access, with `x_we_n` = 0, never drives data: `x_drive` is 0 in the cycle that follows it.
- R5: A read access, with `x_we_n` = 1, drives exactly the enabled lanes. When both lane enables are 1 the access neither writes nor drives.
- R6: For an access captured at clock edge N, `x_rdata` and `x_drive` hold the result from edge N+1 until edge N+2.
- R7: While `x_oe_n` is 1, `x_drive` is 0 at once, with no clock edge needed. Lowering it again restores the drive of the pending read result.
- R8: A synchronous active-high `rst` forces both `drive` outputs to 0 and cancels any access held in the input registers. Stored words are kept.
- R9: When both ports write the same word on the same edge, port B's data lands in every lane that both ports enable.
- R10: When one port reads a word that is being written on the same edge, by either port, the read returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| a_sel_n | input | 1 | Port A select, active low |
| a_sel | input | 1 | Port A select, active high |
| a_we_n | input | 1 | Port A: 0 = write, 1 = read |
| a_lane_n | input | LANES | Port A lane enables, active low, bit 0 = low lane |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | LANES*LANE_W | Port A write data |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_rdata | output | LANES*LANE_W | Port A registered read data |
| a_drive | output | LANES | Port A per-lane drive; 1 = lane of a_rdata is valid and driven |
| b_sel_n | input | 1 | Port B select, active low |
| b_sel | input | 1 | Port B select, active high |
| b_we_n | input | 1 | Port B: 0 = write, 1 = read |
| b_lane_n | input | LANES | Port B lane enables, active low, bit 0 = low lane |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | LANES*LANE_W | Port B write data |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_rdata | output | LANES*LANE_W | Port B registered read data |
| b_drive | output | LANES | Port B per-lane drive |

## Verification
The hardest cases to reach from the ports arise when both ports meet on one word at the same clock edge: a two-sided write with overlapping lanes, and a read that races a write from the other port. Random traffic rarely lines these up. The stimulus therefore drives both ports in one cycle on purpose, with fixed addresses and lane patterns. The bench's reference model settles each edge in a fixed order: it gathers all reads first, then applies port A's writes, then port B's. The asynchronous output enable is raised between edges while a read result is pending, so the bench can observe the drive vector drop without a clock.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // A port is live only for the select pair (0,1) and at least one enabled lane.
  function automatic op_e classify(input logic sel_n, input logic sel,
                                   input logic we_n, input logic any_lane);
    if (sel_n || !sel || !any_lane) return OP_NONE;
    return we_n ? OP_READ : OP_WRITE;
  endfunction

endpackage

// File: rtl/dpr_port_in.sv
module dpr_port_in
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              sel,
  input  logic              we_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [LANES-1:0]  wr_lanes_q,
  output logic [LANES-1:0]  rd_lanes_q
);

  op_e op;

  always_comb op = classify(sel_n, sel, we_n, ~&lane_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_lanes_q <= '0;
      rd_lanes_q <= '0;
    end else begin
      wr_lanes_q <= (op == OP_WRITE) ? ~lane_n : '0;
      rd_lanes_q <= (op == OP_READ)  ? ~lane_n : '0;
    end
  end

  // Address and data need no reset: the lane masks qualify them.
  always_ff @(posedge clk) begin
    addr_q  <= addr;
    wdata_q <= wdata;
  end

endmodule

// File: rtl/dpr_lane_mem.sv
module dpr_lane_mem #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [LANE_W-1:0] a_wd,
  output logic [LANE_W-1:0] a_rd,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [LANE_W-1:0] b_wd,
  output logic [LANE_W-1:0] b_rd
);

  logic [LANE_W-1:0] mem [DEPTH];

  // Read-first on both ports; port B's write is issued last and so wins a tie.
  always_ff @(posedge clk) begin
    a_rd <= mem[a_addr];
    b_rd <= mem[b_addr];
    if (a_we) mem[a_addr] <= a_wd;
    if (b_we) mem[b_addr] <= b_wd;
  end

endmodule

// File: rtl/dpr_out_stage.sv
module dpr_out_stage #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] rd_lanes,
  input  logic             oe_n,
  output logic [LANES-1:0] drive
);

  logic [LANES-1:0] drive_q;

  always_ff @(posedge clk) begin
    if (rst) drive_q <= '0;
    else     drive_q <= rd_lanes;
  end

  // Output enable acts without a clock.
  assign drive = drive_q & {LANES{~oe_n}};

endmodule

// File: rtl/dpr_dualport.sv
module dpr_dualport #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_sel_n,
  input  logic              a_sel,
  input  logic              a_we_n,
  input  logic [LANES-1:0]  a_lane_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              a_oe_n,
  output logic [DATA_W-1:0] a_rdata,
  output logic [LANES-1:0]  a_drive,
  input  logic              b_sel_n,
  input  logic              b_sel,
  input  logic              b_we_n,
  input  logic [LANES-1:0]  b_lane_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              b_oe_n,
  output logic [DATA_W-1:0] b_rdata,
  output logic [LANES-1:0]  b_drive
);

  logic [ADDR_W-1:0] a_addr_q, b_addr_q;
  logic [DATA_W-1:0] a_wd_q, b_wd_q;
  logic [LANES-1:0]  a_wr_q, b_wr_q, a_rd_q, b_rd_q;

  dpr_port_in #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_in_a (
    .clk(clk), .rst(rst), .sel_n(a_sel_n), .sel(a_sel), .we_n(a_we_n),
    .lane_n(a_lane_n), .addr(a_addr), .wdata(a_wdata),
    .addr_q(a_addr_q), .wdata_q(a_wd_q), .wr_lanes_q(a_wr_q), .rd_lanes_q(a_rd_q)
  );

  dpr_port_in #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_in_b (
    .clk(clk), .rst(rst), .sel_n(b_sel_n), .sel(b_sel), .we_n(b_we_n),
    .lane_n(b_lane_n), .addr(b_addr), .wdata(b_wdata),
    .addr_q(b_addr_q), .wdata_q(b_wd_q), .wr_lanes_q(b_wr_q), .rd_lanes_q(b_rd_q)
  );

  // One independent array per lane; its read register is the output stage.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dpr_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_mem (
      .clk   (clk),
      .a_we  (a_wr_q[g]),
      .a_addr(a_addr_q),
      .a_wd  (a_wd_q[g*LANE_W +: LANE_W]),
      .a_rd  (a_rdata[g*LANE_W +: LANE_W]),
      .b_we  (b_wr_q[g]),
      .b_addr(b_addr_q),
      .b_wd  (b_wd_q[g*LANE_W +: LANE_W]),
      .b_rd  (b_rdata[g*LANE_W +: LANE_W])
    );
  end

  dpr_out_stage #(.LANES(LANES)) u_out_a (
    .clk(clk), .rst(rst), .rd_lanes(a_rd_q), .oe_n(a_oe_n), .drive(a_drive)
  );

  dpr_out_stage #(.LANES(LANES)) u_out_b (
    .clk(clk), .rst(rst), .rd_lanes(b_rd_q), .oe_n(b_oe_n), .drive(b_drive)
  );

endmodule

// File: rtl/dpr_checks.sv
module dpr_checks #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             a_sel_n,
  input logic             a_sel,
  input logic             a_we_n,
  input logic [LANES-1:0] a_lane_n,
  input logic             a_oe_n,
  input logic [LANES-1:0] a_drive,
  input logic             b_sel_n,
  input logic             b_sel,
  input logic             b_we_n,
  input logic [LANES-1:0] b_lane_n,
  input logic             b_oe_n,
  input logic [LANES-1:0] b_drive
);

  // Set once an edge without reset has passed, so $past sees captured inputs.
  logic up_q;
  always_ff @(posedge clk) begin
    if (rst) up_q <= 1'b0;
    else     up_q <= 1'b1;
  end

  p_desel_quiet_r2_a: assert property (@(posedge clk) disable iff (rst)
    (up_q && !(!$past(a_sel_n) && $past(a_sel))) |=> (a_drive == '0));
  p_desel_quiet_r2_b: assert property (@(posedge clk) disable iff (rst)
    (up_q && !(!$past(b_sel_n) && $past(b_sel))) |=> (b_drive == '0));

  p_write_quiet_r4_a: assert property (@(posedge clk) disable iff (rst)
    (up_q && !$past(a_sel_n) && $past(a_sel) && !$past(a_we_n)) |=> (a_drive == '0));
  p_write_quiet_r4_b: assert property (@(posedge clk) disable iff (rst)
    (up_q && !$past(b_sel_n) && $past(b_sel) && !$past(b_we_n)) |=> (b_drive == '0));

  p_read_lanes_r5_a: assert property (@(posedge clk) disable iff (rst)
    (up_q && !$past(a_sel_n) && $past(a_sel) && $past(a_we_n))
    |=> (a_drive == (~$past(a_lane_n, 2) & {LANES{~a_oe_n}})));
  p_read_lanes_r5_b: assert property (@(posedge clk) disable iff (rst)
    (up_q && !$past(b_sel_n) && $past(b_sel) && $past(b_we_n))
    |=> (b_drive == (~$past(b_lane_n, 2) & {LANES{~b_oe_n}})));

  p_oe_float_r7_a: assert property (@(posedge clk) disable iff (rst)
    a_oe_n |-> (a_drive == '0));
  p_oe_float_r7_b: assert property (@(posedge clk) disable iff (rst)
    b_oe_n |-> (b_drive == '0));

endmodule

bind dpr_dualport dpr_checks #(.LANES(LANES)) u_checks (
  .clk(clk), .rst(rst),
  .a_sel_n(a_sel_n), .a_sel(a_sel), .a_we_n(a_we_n), .a_lane_n(a_lane_n),
  .a_oe_n(a_oe_n), .a_drive(a_drive),
  .b_sel_n(b_sel_n), .b_sel(b_sel), .b_we_n(b_we_n), .b_lane_n(b_lane_n),
  .b_oe_n(b_oe_n), .b_drive(b_drive)
);

// File: tb/sim_dpr_dualport.sv
module sim_dpr_dualport;
  localparam int AW = 10;
  localparam int LW = 9;
  localparam int NL = 2;
  localparam int DW = LW * NL;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst;
  logic a_sel_n, a_sel, a_we_n, a_oe_n, b_sel_n, b_sel, b_we_n, b_oe_n;
  logic [NL-1:0] a_lane_n, b_lane_n, a_drive, b_drive;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;

  dpr_dualport #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) u0 (
    .clk(clk), .rst(rst),
    .a_sel_n(a_sel_n), .a_sel(a_sel), .a_we_n(a_we_n), .a_lane_n(a_lane_n),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_oe_n(a_oe_n),
    .a_rdata(a_rdata), .a_drive(a_drive),
    .b_sel_n(b_sel_n), .b_sel(b_sel), .b_we_n(b_we_n), .b_lane_n(b_lane_n),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_oe_n(b_oe_n),
    .b_rdata(b_rdata), .b_drive(b_drive)
  );

  int total = 0;
  int bad = 0;
  string tag = "R8";
  bit chk_on = 1'b0;

  // Reference model: a plain word array plus one pending access per port.
  typedef struct packed {
    logic          rd;
    logic          wr;
    logic [NL-1:0] ln;
    logic [AW-1:0] ad;
    logic [DW-1:0] wd;
  } req_t;

  logic [DW-1:0] mdl [DEPTH];
  req_t pa = '0, pb = '0;
  logic [NL-1:0] ea = '0, eb = '0;
  logic [DW-1:0] xa = '0, xb = '0;

  function automatic req_t take(input logic sn, input logic s, input logic wn,
                                input logic [NL-1:0] ln, input logic [AW-1:0] ad,
                                input logic [DW-1:0] wd);
    req_t r = '0;
    if (!sn && s && ln != {NL{1'b1}}) begin
      if (wn) r.rd = 1'b1; else r.wr = 1'b1;
      r.ln = ~ln;
    end
    r.ad = ad;
    r.wd = wd;
    return r;
  endfunction

  function automatic logic [DW-1:0] bits_of(input logic [NL-1:0] ln);
    logic [DW-1:0] m = '0;
    for (int i = 0; i < NL; i++) m[i*LW +: LW] = {LW{ln[i]}};
    return m;
  endfunction

  always @(posedge clk) begin
    // reads see the old word, then A writes, then B writes
    ea = pa.rd ? pa.ln : '0;
    eb = pb.rd ? pb.ln : '0;
    if (pa.rd) xa = mdl[pa.ad];
    if (pb.rd) xb = mdl[pb.ad];
    if (pa.wr) mdl[pa.ad] = (mdl[pa.ad] & ~bits_of(pa.ln)) | (pa.wd & bits_of(pa.ln));
    if (pb.wr) mdl[pb.ad] = (mdl[pb.ad] & ~bits_of(pb.ln)) | (pb.wd & bits_of(pb.ln));
    if (rst) begin
      ea = '0; eb = '0; pa = '0; pb = '0;
    end else begin
      pa = take(a_sel_n, a_sel, a_we_n, a_lane_n, a_addr, a_wdata);
      pb = take(b_sel_n, b_sel, b_we_n, b_lane_n, b_addr, b_wdata);
    end
  end

  task automatic check_port(input string p, input logic [NL-1:0] gd, input logic [DW-1:0] gq,
                            input logic [NL-1:0] ed, input logic [DW-1:0] eq);
    bit ok = (gd === ed);
    for (int i = 0; i < NL; i++)
      if (ed[i] && gq[i*LW +: LW] !== eq[i*LW +: LW]) ok = 1'b0;
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s port %s: drive=%b rdata=%h expected drive=%b rdata=%h (t=%0t)",
               tag, p, gd, gq, ed, eq, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      check_port("A", a_drive, a_rdata, ea & {NL{~a_oe_n}}, xa);
      check_port("B", b_drive, b_rdata, eb & {NL{~b_oe_n}}, xb);
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_all();
    a_sel_n = 1'b1; a_sel = 1'b0; a_we_n = 1'b1; a_lane_n = '1;
    b_sel_n = 1'b1; b_sel = 1'b0; b_we_n = 1'b1; b_lane_n = '1;
  endtask

  // port 0 = A, 1 = B; selected access with the given lanes
  task automatic acc(input bit port, input bit wr, input logic [NL-1:0] ln,
                     input int ad, input logic [DW-1:0] wd);
    if (!port) begin
      a_sel_n = 1'b0; a_sel = 1'b1; a_we_n = ~wr; a_lane_n = ln;
      a_addr = AW'(ad); a_wdata = wd;
    end else begin
      b_sel_n = 1'b0; b_sel = 1'b1; b_we_n = ~wr; b_lane_n = ln;
      b_addr = AW'(ad); b_wdata = wd;
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete, got running expected finished");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    idle_all();
    a_oe_n = 1'b0; b_oe_n = 1'b0;
    a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0;
    // R8: drive low during and right after reset
    step();
    chk_on = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    step();

    // R1: fill every word, A on even, B on odd addresses; cross-read
    tag = "R1";
    for (int i = 0; i < DEPTH / 2; i++) begin
      acc(0, 1, 2'b00, 2 * i, DW'($urandom));
      acc(1, 1, 2'b00, 2 * i + 1, DW'($urandom));
      step();
    end
    for (int i = 0; i < DEPTH / 2; i++) begin
      acc(0, 0, 2'b00, 2 * i + 1, '0);
      acc(1, 0, 2'b00, 2 * i, '0);
      step();
    end
    idle_all(); step();

    // R3: single-lane writes leave the other lane intact
    tag = "R3";
    acc(0, 1, 2'b01, 5, 18'h3FFFF); step();
    acc(0, 1, 2'b10, 6, 18'h3FFFF); step();
    idle_all();
    acc(1, 0, 2'b00, 5, '0); step();
    acc(1, 0, 2'b00, 6, '0); step();
    idle_all(); step();

    // R2: every non-selecting combination blocks writes and drive
    tag = "R2";
    acc(0, 1, 2'b00, 7, 18'h12345); a_sel_n = 1'b1; step();
    acc(0, 1, 2'b00, 7, 18'h0ABCD); a_sel = 1'b0;   step();
    acc(0, 1, 2'b00, 7, 18'h15555); a_sel_n = 1'b1; a_sel = 1'b0; step();
    acc(1, 0, 2'b00, 7, '0); b_sel = 1'b0; step();
    idle_all();
    acc(0, 0, 2'b00, 7, '0); step();
    idle_all(); step();

    // R5: lane-selective reads and the no-lane access
    tag = "R5";
    acc(0, 0, 2'b01, 5, '0); step();
    acc(0, 0, 2'b10, 5, '0); step();
    acc(0, 0, 2'b11, 5, '0); step();
    acc(0, 1, 2'b11, 8, 18'h2AAAA); step();
    acc(0, 0, 2'b00, 8, '0); step();
    idle_all(); step();

    // R4: writes on both ports report no drive
    tag = "R4";
    acc(0, 1, 2'b00, 20, 18'h01111); acc(1, 1, 2'b00, 21, 18'h02222); step();
    idle_all(); step();

    // R6: write then immediate read-back on the next edge
    tag = "R6";
    acc(0, 1, 2'b00, 9, 18'h13579); step();
    acc(0, 0, 2'b00, 9, '0); step();
    idle_all(); step();

    // R10: read races a write of the same word from the other port
    tag = "R10";
    acc(0, 1, 2'b00, 12, 18'h2468A); acc(1, 0, 2'b00, 12, '0); step();
    acc(1, 1, 2'b00, 12, 18'h3C3C3); acc(0, 0, 2'b00, 12, '0); step();
    idle_all();
    acc(0, 0, 2'b00, 12, '0); step();
    idle_all(); step();

    // R9: both ports write one word on the same edge
    tag = "R9";
    acc(0, 1, 2'b00, 10, 18'h0AAAA); acc(1, 1, 2'b00, 10, 18'h15555); step();
    acc(0, 1, 2'b00, 11, 18'h00F0F); acc(1, 1, 2'b01, 11, 18'h3F0F0); step();
    idle_all();
    acc(0, 0, 2'b00, 10, '0); acc(1, 0, 2'b00, 11, '0); step();
    idle_all(); step();

    // R7: raise the output enable between edges while a read is pending
    tag = "R7";
    acc(0, 0, 2'b00, 9, '0); acc(1, 0, 2'b00, 10, '0); step();
    idle_all();
    a_oe_n = 1'b1; step();
    a_oe_n = 1'b0; b_oe_n = 1'b1;
    acc(0, 0, 2'b00, 9, '0); step();
    b_oe_n = 1'b0; idle_all(); step();

    // R1: mixed traffic with random selects, lanes and output enables
    tag = "R1";
    for (int i = 0; i < 600; i++) begin
      int aa = $urandom_range(0, 31);
      int ba = $urandom_range(0, 31);
      bit aw = 1'($urandom);
      bit bw = 1'($urandom);
      if (aw && bw && aa == ba) bw = 1'b0;
      acc(0, aw, NL'($urandom), aa, DW'($urandom));
      acc(1, bw, NL'($urandom), ba, DW'($urandom));
      if ($urandom_range(0, 7) == 0) a_sel = 1'b0;
      if ($urandom_range(0, 7) == 0) b_sel_n = 1'b1;
      a_oe_n = ($urandom_range(0, 5) == 0);
      b_oe_n = ($urandom_range(0, 5) == 0);
      step();
    end
    a_oe_n = 1'b0; b_oe_n = 1'b0; idle_all(); step();

    // R8: reset mid-stream clears drive but keeps stored words
    tag = "R8";
    acc(0, 0, 2'b00, 9, '0); acc(1, 0, 2'b00, 10, '0); step();
    rst = 1'b1; step();
    rst = 1'b0; step();
    acc(0, 0, 2'b00, 9, '0); acc(1, 0, 2'b00, 10, '0); step();
    idle_all(); step(); step();

    summary();
    $finish;
  end

endmodule